// File: doc/BRIEF.md
# Serial Wiper Code Loader

This block is the serial front end of a four-channel wiper-setting register bank. A host sends one 10-bit word per chip-select window over a three-wire serial link. The two leading bits name the target channel and the eight trailing bits are the new wiper code. The word takes effect when chip select returns high. A window that does not hold exactly ten clock edges leaves every channel as it was.

The most significant bit of the internal shift register is driven on a serial output. Several loaders can therefore sit in a chain, each one passing on what it received. All pins are resynchronised to the system clock before use. An active-low reset puts every channel at mid-scale. A select input turns the serial port off when it is high.

Top module: `spi_wiper_loader`

## Requirements
- R1: While `rstN` is low, every channel code is 0x80 and `sdoOe` is 0. Both values are kept after reset is released, until a valid frame is committed.
- R2: A frame is sent MSB first. Serial bit 9 (the first bit) and bit 8 form the channel address, and bits 7..0 form the code, with bit 7 sent third.
- R3: Address 0, 1, 2 or 3 loads channel 0, 1, 2 or 3. Channel n is driven on `wiperCodes[8n+7:8n]`.
- R4: A commit shows on `wiperCodes` at the third rising system-clock edge after `spiCsN` goes high, and not before.
- R5: A chip-select window with fewer or more than 10 serial clock rising edges changes no channel.
- R6: `sdoData` is the bit that was shifted in 10 serial edges earlier. After a frame of exactly 10 edges, it equals that frame's first bit.
- R7: `sdoOe` is 1 while the port is enabled and chip select is low, and 0 otherwise. The open-drain pin is pulled low only when `sdoOe` is 1 and `sdoData` is 0.
- R8: While `ifSel` is 1, serial edges are not shifted, no channel loads and `sdoOe` stays 0.
- R9: Serial clock edges while chip select is high shift nothing and load nothing.
- R10: A commit changes only the addressed channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset; forces mid-scale codes |
| ifSel | input | 1 | Port select; 0 enables the serial port |
| spiClk | input | 1 | Serial clock; data is taken on its rising edge |
| spiCsN | input | 1 | Active-low chip select; its rising edge commits the frame |
| spiSdi | input | 1 | Serial data in |
| sdoData | output | 1 | Serial data out value (the MSB of the shift register) |
| sdoOe | output | 1 | Serial data out enable for the open-drain driver |
| wiperCodes | output | 32 | Channel codes; channel n is in bits 8n+7..8n |

## Verification
Each serial pin passes through two synchroniser flops and one edge-history flop. A serial clock rise therefore shifts on the third system edge after it, and a chip-select rise loads a channel on the third edge after it. `sdoOe` follows chip select two edges after it changes. The bench keeps a behavioural model that delays its sampled inputs by the same number of edges. The model is compared with the outputs at every falling edge, away from the edges where the outputs update. A directed latency test raises chip select just after a rising edge and checks that the channel still holds its old code after two edges and holds the new code after three.

// File: rtl/spi_wl_pkg.sv
package spi_wl_pkg;
  // strobes from the framing control to the datapath
  typedef struct packed {
    logic shiftBit;  // take one synchronised serial bit
    logic commit;    // write the framed code into the addressed channel
  } wlStrobe_t;
endpackage

// File: rtl/spi_wl_ctrl.sv
module spi_wl_ctrl
  import spi_wl_pkg::*;
#(
  parameter int FRAME_W = 10
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      ifSel,
  input  logic      spiClk,
  input  logic      spiCsN,
  output wlStrobe_t stb,
  output logic      sdoOe
);
  localparam int CNT_MAX = FRAME_W + 1;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  // [0] first sync stage, [1] synchronised, [2] previous synchronised
  logic [2:0] clkPipe;
  logic [2:0] csPipe;
  logic [1:0] selPipe;
  logic [CNT_W-1:0] bitCnt;
  logic active, sclkRise, csRise;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkPipe <= '0;
      csPipe  <= '1;
      selPipe <= '1;
    end else begin
      clkPipe <= {clkPipe[1:0], spiClk};
      csPipe  <= {csPipe[1:0], spiCsN};
      selPipe <= {selPipe[0], ifSel};
    end
  end

  assign active   = !selPipe[1];
  assign sclkRise = clkPipe[1] && !clkPipe[2] && !csPipe[1] && active;
  assign csRise   = csPipe[1] && !csPipe[2];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
    end else if (csRise) begin
      bitCnt <= '0;
    end else if (sclkRise && bitCnt != CNT_W'(CNT_MAX)) begin
      bitCnt <= bitCnt + 1'b1;
    end
  end

  always_comb begin
    stb          = '0;
    stb.shiftBit = sclkRise;
    stb.commit   = csRise && active && (bitCnt == CNT_W'(FRAME_W));
  end

  assign sdoOe = active && !csPipe[1];

  AST_CNT_BOUNDED: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= CNT_W'(CNT_MAX)); // R5
  AST_COMMIT_RESTARTS: assert property (@(posedge clk) disable iff (!rstN)
    stb.commit |=> bitCnt == '0); // R4
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    selPipe[1] |-> !stb.shiftBit && !stb.commit && !sdoOe); // R8
  AST_CS_HIGH_NO_SHIFT: assert property (@(posedge clk) disable iff (!rstN)
    csPipe[1] |-> !stb.shiftBit); // R9
endmodule

// File: rtl/spi_wl_datapath.sv
module spi_wl_datapath
  import spi_wl_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CODE_W = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     spiSdi,
  input  wlStrobe_t                stb,
  output logic                     sdoData,
  output logic [NUM_CH*CODE_W-1:0] wiperCodes
);
  localparam int ADDR_W  = $clog2(NUM_CH);
  localparam int FRAME_W = ADDR_W + CODE_W;
  localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(1) << (CODE_W - 1);

  logic [1:0] sdiPipe;
  logic [FRAME_W-1:0] shiftReg;
  logic [ADDR_W-1:0] frameAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sdiPipe  <= '0;
      shiftReg <= '0;
    end else begin
      sdiPipe <= {sdiPipe[0], spiSdi};
      if (stb.shiftBit) shiftReg <= {shiftReg[FRAME_W-2:0], sdiPipe[1]};
    end
  end

  assign frameAddr = shiftReg[FRAME_W-1 -: ADDR_W];
  assign sdoData   = shiftReg[FRAME_W-1];

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : gChan
    logic [CODE_W-1:0] code;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        code <= MID_CODE;
      end else if (stb.commit && frameAddr == ADDR_W'(ch)) begin
        code <= shiftReg[CODE_W-1:0];
      end
    end
    assign wiperCodes[ch*CODE_W +: CODE_W] = code;
  end

  AST_HOLD_WITHOUT_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    !stb.commit |=> $stable(wiperCodes)); // R5
  AST_SDO_TRAILS_SHIFT: assert property (@(posedge clk) disable iff (!rstN)
    stb.shiftBit |=> sdoData == $past(shiftReg[FRAME_W-2])); // R6
  AST_NO_SHIFT_HOLDS_SDO: assert property (@(posedge clk) disable iff (!rstN)
    !stb.shiftBit |=> $stable(sdoData)); // R9
endmodule

// File: rtl/spi_wiper_loader.sv
module spi_wiper_loader
  import spi_wl_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CODE_W = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     ifSel,
  input  logic                     spiClk,
  input  logic                     spiCsN,
  input  logic                     spiSdi,
  output logic                     sdoData,
  output logic                     sdoOe,
  output logic [NUM_CH*CODE_W-1:0] wiperCodes
);
  localparam int FRAME_W = $clog2(NUM_CH) + CODE_W;

  wlStrobe_t stb;

  spi_wl_ctrl #(.FRAME_W(FRAME_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .ifSel(ifSel), .spiClk(spiClk),
    .spiCsN(spiCsN), .stb(stb), .sdoOe(sdoOe)
  );

  spi_wl_datapath #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) dp_i (
    .clk(clk), .rstN(rstN), .spiSdi(spiSdi), .stb(stb),
    .sdoData(sdoData), .wiperCodes(wiperCodes)
  );
endmodule

// File: tb/spi_wiper_loader_tb_top.sv
module spi_wiper_loader_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0, ifSel = 1'b0, spiClk = 1'b0, spiCsN = 1'b1, spiSdi = 1'b0;
  logic sdoData, sdoOe;
  logic [31:0] wiperCodes;
  int nChecks = 0, nFails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  spi_wiper_loader dut_i (
    .clk(clk), .rstN(rstN), .ifSel(ifSel), .spiClk(spiClk), .spiCsN(spiCsN),
    .spiSdi(spiSdi), .sdoData(sdoData), .sdoOe(sdoOe), .wiperCodes(wiperCodes)
  );

  // behavioural model: inputs seen through a three-edge delay line
  bit qClk[3], qCs[3], qSdi[3], qSel[3];
  bit [9:0] mShift;
  bit [7:0] mCode[4];
  int mEdges;
  bit mOe;

  task automatic modelReset();
    for (int i = 0; i < 3; i++) begin
      qClk[i] = 0; qCs[i] = 1; qSdi[i] = 0; qSel[i] = 1;
    end
    mShift = '0; mEdges = 0; mOe = 0;
    for (int c = 0; c < 4; c++) mCode[c] = 8'h80;
  endtask

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modelReset();
    end else begin
      if (qCs[1] && !qCs[2]) begin
        if (mEdges == 10 && !qSel[1]) mCode[mShift[9:8]] = mShift[7:0];
        mEdges = 0;
      end else if (qClk[1] && !qClk[2] && !qCs[1] && !qSel[1]) begin
        mShift = {mShift[8:0], qSdi[1]};
        if (mEdges < 11) mEdges++;
      end
      for (int i = 2; i > 0; i--) begin
        qClk[i] = qClk[i-1]; qCs[i] = qCs[i-1]; qSdi[i] = qSdi[i-1]; qSel[i] = qSel[i-1];
      end
      qClk[0] = spiClk; qCs[0] = spiCsN; qSdi[0] = spiSdi; qSel[0] = ifSel;
      mOe = !qSel[1] && !qCs[1];
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      chk("R4 model codes", wiperCodes, {mCode[3], mCode[2], mCode[1], mCode[0]});
      chk("R6 model sdoData", {31'd0, sdoData}, {31'd0, mShift[9]});
      chk("R7 model sdoOe", {31'd0, sdoOe}, {31'd0, mOe});
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic shiftBits(logic [15:0] w, int n);
    spiCsN = 1'b0;
    tick(4);
    for (int i = n - 1; i >= 0; i--) begin
      spiSdi = w[i];
      tick(3); spiClk = 1'b1;
      tick(3); spiClk = 1'b0;
    end
    tick(3);
  endtask

  task automatic sendFrame(logic [15:0] w, int n);
    shiftBits(w, n);
    spiCsN = 1'b1;
    tick(6);
  endtask

  initial begin
    tick(5);
    chk("R1 codes in reset", wiperCodes, 32'h80808080);
    chk("R1 sdoOe in reset", {31'd0, sdoOe}, 32'd0);
    rstN = 1'b1;
    tick(3);
    chk("R1 codes after release", wiperCodes, 32'h80808080);

    sendFrame(16'h23C, 10);
    chk("R2 R10 addr2 code 3C", wiperCodes, 32'h803C8080);
    sendFrame(16'h0A5, 10);
    chk("R3 addr0", wiperCodes, 32'h803C80A5);
    sendFrame(16'h101, 10);
    chk("R3 addr1", wiperCodes, 32'h803C01A5);
    sendFrame(16'h3FF, 10);
    chk("R3 addr3", wiperCodes, 32'hFF3C01A5);

    sendFrame(16'h077, 9);
    chk("R5 nine edges discarded", wiperCodes, 32'hFF3C01A5);
    sendFrame(16'h488, 11);
    chk("R5 eleven edges discarded", wiperCodes, 32'hFF3C01A5);

    sendFrame(16'h312, 10);
    chk("R6 sdo after frame 312", {31'd0, sdoData}, 32'd1);
    chk("R3 addr3 code 12", wiperCodes, 32'h123C01A5);
    for (int i = 0; i < 12; i++) begin
      spiSdi = ~spiSdi;
      tick(3); spiClk = 1'b1; tick(3); spiClk = 1'b0;
    end
    tick(4);
    chk("R9 cs high edges ignored codes", wiperCodes, 32'h123C01A5);
    chk("R9 cs high edges ignored sdo", {31'd0, sdoData}, 32'd1);

    sendFrame(16'h155, 10);
    chk("R6 sdo after frame 155", {31'd0, sdoData}, 32'd0);
    chk("R10 addr1 only", wiperCodes, 32'h123C55A5);

    spiCsN = 1'b0; tick(4);
    chk("R7 oe while selected", {31'd0, sdoOe}, 32'd1);
    spiCsN = 1'b1; tick(4);
    chk("R7 oe after deselect", {31'd0, sdoOe}, 32'd0);

    ifSel = 1'b1; tick(4);
    shiftBits(16'h0AA, 10);
    chk("R8 oe off when disabled", {31'd0, sdoOe}, 32'd0);
    spiCsN = 1'b1; tick(6);
    chk("R8 no load when disabled", wiperCodes, 32'h123C55A5);
    ifSel = 1'b0; tick(4);

    shiftBits(16'h2C3, 10);
    @(posedge clk); #2;
    spiCsN = 1'b1;
    repeat (3) @(negedge clk);
    chk("R4 old code two edges after cs rise", wiperCodes, 32'h123C55A5);
    @(negedge clk);
    chk("R4 new code three edges after cs rise", wiperCodes, 32'h12C355A5);
    tick(4);

    rstN = 1'b0; tick(2);
    chk("R1 codes on reset", wiperCodes, 32'h80808080);
    rstN = 1'b1; tick(3);
    chk("R1 codes held after reset", wiperCodes, 32'h80808080);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    done = 1'b1;
    nChecks++; nFails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule